// File: doc/BRIEF.md
# Dual-Clock I/Q Sample Output Stage

This block moves complex baseband samples out of a fast processing clock domain and into a slower sampling clock domain. The sampling domain drives two RF paths, A and B. On the processing side, a producer offers I/Q samples under valid/ready flow control and flags the final sample of each packet. A transmission-begin strobe captures a path-enable mask, and that mask travels with every sample written after it.

On the sampling side, the radio consumes samples by holding a read-enable high. Each sampling clock edge with the enable high presents the next sample on both paths. A path whose mask bit is clear carries zero. When no sample is waiting, all outputs carry zero.

Two status indications are returned to the processing domain. The first is a level that rises once the first sample of a packet has left the sampling side. The second is a one-cycle pulse raised after the last sample has left. Both are carried back through toggle synchronizers.

Top module: `iq_cdc_out`

## Requirements
- R1: `in_ready` is low exactly while the buffer holds `2**ADDR_W` entries. A sample offered with `in_valid` high while `in_ready` is low is not stored.
- R2: Samples leave the sampling side in the order they were accepted. Each `samp_clk` edge with `rd_en` high and a sample waiting loads the next sample into the path outputs.
- R3: A `samp_clk` edge with `rd_en` low leaves all four outputs unchanged.
- R4: A `samp_clk` edge with `rd_en` high and no sample waiting drives all four outputs to zero.
- R5: Bit 0 of `ant_mask` enables path A and bit 1 enables path B. A disabled path outputs zero. The mask is captured on `tx_begin` and applies to every sample accepted from that cycle until the next `tx_begin`, even when samples of both masks are in the buffer at once. Reset clears the captured mask to 0.
- R6: `tx_started` rises in the processing domain after the first sample of a packet is output. It falls the cycle after the matching `tx_done` pulse.
- R7: `tx_done` pulses high for exactly one `proc_clk` cycle per packet, after that packet's last sample (accepted with `in_last` high) is output, and not before.
- R8: With `proc_rst` and `samp_rst` asserted together (synchronous, active high), the buffer empties, all outputs are zero, `in_ready` is high, and `tx_started`/`tx_done` are low.
- R9: With `proc_clk` at least four times the `samp_clk` rate and a producer that keeps `in_valid` high, a packet read with `rd_en` held high after the buffer first fills outputs every sample in sequence, with no zero inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| proc_clk | input | 1 | Processing clock |
| proc_rst | input | 1 | Synchronous active-high reset, processing domain |
| tx_begin | input | 1 | Strobe that captures `ant_mask` for the next transmission |
| ant_mask | input | 2 | Path enable: bit 0 path A, bit 1 path B |
| in_valid | input | 1 | Input sample valid |
| in_i | input | 16 | In-phase sample, signed, 15 fractional bits |
| in_q | input | 16 | Quadrature sample, signed, 15 fractional bits |
| in_last | input | 1 | Marks the final sample of a packet |
| in_ready | output | 1 | Buffer can accept a sample |
| tx_started | output | 1 | First sample of current packet has been output |
| tx_done | output | 1 | One-cycle pulse after last sample output |
| samp_clk | input | 1 | Sampling clock |
| samp_rst | input | 1 | Synchronous active-high reset, sampling domain |
| rd_en | input | 1 | Consumer request for a new sample each edge |
| rfa_i | output | 16 | Path A in-phase output |
| rfa_q | output | 16 | Path A quadrature output |
| rfb_i | output | 16 | Path B in-phase output |
| rfb_q | output | 16 | Path B quadrature output |

## Verification
The bench builds the block with `ADDR_W = 2`, a four-entry buffer, and `SYNC_STAGES = 2`. This lets full-buffer backpressure and discarded offers appear after only four writes. The sampling clock period is a non-integer multiple of the processing period, a little over four times it. That places the streaming test just inside the guaranteed rate ratio. With only four entries, a pointer-synchronization lag that breaks the no-underflow property shows up as an inserted zero. Packets with different masks are queued together to show that the mask travels with each sample.

// File: rtl/iqo_pkg.sv
package iqo_pkg;

    localparam int IQ_W  = 16;
    localparam int NPATH = 2;

    typedef logic signed [IQ_W-1:0] iq_t;

    typedef struct packed {
        iq_t i;
        iq_t q;
    } iq_pair_t;

    typedef struct packed {
        logic             last;
        logic [NPATH-1:0] mask;
        iq_pair_t         s;
    } fifo_ent_t;

    localparam int ENT_W = $bits(fifo_ent_t);

    function automatic iq_pair_t gate_pair(input iq_pair_t s, input logic en);
        return en ? s : '0;
    endfunction

endpackage

// File: rtl/iqo_sync.sv
module iqo_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/iqo_afifo.sv
module iqo_afifo #(
    parameter int ADDR_W      = 3,
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         wclk,
    input  logic         wrst,
    input  logic         push,
    input  logic [W-1:0] wdata,
    output logic         full,
    input  logic         rclk,
    input  logic         rrst,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int PW    = ADDR_W + 1;

    function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int k = PW - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
        return b;
    endfunction

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wbin, wgray, rgray_w;
    logic [PW-1:0] rbin, rgray, wgray_r;
    logic          do_push, do_pop;

    // write side
    assign full    = (wbin - g2b(rgray_w)) == PW'(DEPTH);
    assign do_push = push & ~full;

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (do_push) begin
            wbin  <= wbin + 1'b1;
            wgray <= b2g(wbin + 1'b1);
        end
    end

    always_ff @(posedge wclk) begin
        if (do_push) mem[wbin[ADDR_W-1:0]] <= wdata;
    end

    iqo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_rptr_sync (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_w)
    );

    // read side
    assign empty  = (rgray == wgray_r);
    assign do_pop = pop & ~empty;
    assign rdata  = mem[rbin[ADDR_W-1:0]];

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (do_pop) begin
            rbin  <= rbin + 1'b1;
            rgray <= b2g(rbin + 1'b1);
        end
    end

    iqo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_wptr_sync (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_r)
    );
endmodule

// File: rtl/iqo_out_stage.sv
module iqo_out_stage
    import iqo_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  logic                  empty,
    input  fifo_ent_t             head,
    output logic                  pop,
    output iq_pair_t [NPATH-1:0]  path_q,
    output logic                  first_tgl,
    output logic                  last_tgl
);
    iq_pair_t [NPATH-1:0] gated;
    logic                 in_pkt;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        assign gated[p] = gate_pair(head.s, head.mask[p]);
    end

    assign pop = rd_en & ~empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            path_q    <= '0;
            in_pkt    <= 1'b0;
            first_tgl <= 1'b0;
            last_tgl  <= 1'b0;
        end else if (rd_en) begin
            if (pop) begin
                path_q <= gated;
                in_pkt <= ~head.last;
                if (!in_pkt)   first_tgl <= ~first_tgl;
                if (head.last) last_tgl  <= ~last_tgl;
            end else begin
                path_q <= '0;
            end
        end
    end
endmodule

// File: rtl/iqo_evt_ret.sv
module iqo_evt_ret #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic first_tgl,
    input  logic last_tgl,
    output logic started,
    output logic done
);
    logic [1:0] tgl_s, tgl_prev, edge_seen;

    iqo_sync #(.W(2), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk(clk), .rst(rst), .d({last_tgl, first_tgl}), .q(tgl_s)
    );

    assign edge_seen = tgl_s ^ tgl_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_prev <= '0;
            started  <= 1'b0;
            done     <= 1'b0;
        end else begin
            tgl_prev <= tgl_s;
            done     <= edge_seen[1];
            if (edge_seen[0])  started <= 1'b1;
            else if (done)     started <= 1'b0;
        end
    end
endmodule

// File: rtl/iq_cdc_out.sv
module iq_cdc_out
    import iqo_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                   proc_clk,
    input  logic                   proc_rst,
    input  logic                   tx_begin,
    input  logic [NPATH-1:0]       ant_mask,
    input  logic                   in_valid,
    input  logic signed [IQ_W-1:0] in_i,
    input  logic signed [IQ_W-1:0] in_q,
    input  logic                   in_last,
    output logic                   in_ready,
    output logic                   tx_started,
    output logic                   tx_done,
    input  logic                   samp_clk,
    input  logic                   samp_rst,
    input  logic                   rd_en,
    output logic signed [IQ_W-1:0] rfa_i,
    output logic signed [IQ_W-1:0] rfa_q,
    output logic signed [IQ_W-1:0] rfb_i,
    output logic signed [IQ_W-1:0] rfb_q
);
    logic [NPATH-1:0]     mask_q;
    fifo_ent_t            wr_ent, head;
    logic [ENT_W-1:0]     rd_raw;
    logic                 wr_full, rd_empty, rd_pop;
    logic                 first_tgl, last_tgl;
    iq_pair_t [NPATH-1:0] paths;

    always_ff @(posedge proc_clk) begin
        if (proc_rst)      mask_q <= '0;
        else if (tx_begin) mask_q <= ant_mask;
    end

    assign wr_ent.last = in_last;
    assign wr_ent.mask = tx_begin ? ant_mask : mask_q;
    assign wr_ent.s.i  = in_i;
    assign wr_ent.s.q  = in_q;
    assign in_ready    = ~wr_full;

    iqo_afifo #(.ADDR_W(ADDR_W), .W(ENT_W), .SYNC_STAGES(SYNC_STAGES)) u_fifo (
        .wclk(proc_clk), .wrst(proc_rst), .push(in_valid), .wdata(wr_ent), .full(wr_full),
        .rclk(samp_clk), .rrst(samp_rst), .pop(rd_pop), .rdata(rd_raw), .empty(rd_empty)
    );

    assign head = fifo_ent_t'(rd_raw);

    iqo_out_stage u_out (
        .clk(samp_clk), .rst(samp_rst), .rd_en(rd_en), .empty(rd_empty), .head(head),
        .pop(rd_pop), .path_q(paths), .first_tgl(first_tgl), .last_tgl(last_tgl)
    );

    iqo_evt_ret #(.SYNC_STAGES(SYNC_STAGES)) u_evt (
        .clk(proc_clk), .rst(proc_rst), .first_tgl(first_tgl), .last_tgl(last_tgl),
        .started(tx_started), .done(tx_done)
    );

    assign rfa_i = paths[0].i;
    assign rfa_q = paths[0].q;
    assign rfb_i = paths[1].i;
    assign rfb_q = paths[1].q;
endmodule

// File: rtl/iq_cdc_out_chk.sv
module iq_cdc_out_chk
    import iqo_pkg::*;
(
    input logic            proc_clk,
    input logic            proc_rst,
    input logic            samp_clk,
    input logic            samp_rst,
    input logic            rd_en,
    input logic            rd_empty,
    input logic            in_ready,
    input logic            tx_started,
    input logic            tx_done,
    input logic [IQ_W-1:0] rfa_i,
    input logic [IQ_W-1:0] rfa_q,
    input logic [IQ_W-1:0] rfb_i,
    input logic [IQ_W-1:0] rfb_q
);
    AST_DONE_ONE_CYCLE: assert property (@(posedge proc_clk) disable iff (proc_rst)
        tx_done |=> !tx_done);  // R7

    AST_DONE_WITH_START: assert property (@(posedge proc_clk) disable iff (proc_rst)
        tx_done |-> tx_started);  // R6

    AST_HOLD_IDLE: assert property (@(posedge samp_clk) disable iff (samp_rst)
        !rd_en |=> ($stable(rfa_i) && $stable(rfa_q) && $stable(rfb_i) && $stable(rfb_q)));  // R3

    AST_ZERO_ON_EMPTY: assert property (@(posedge samp_clk) disable iff (samp_rst)
        (rd_en && rd_empty) |=> (rfa_i == '0 && rfa_q == '0 && rfb_i == '0 && rfb_q == '0));  // R4

    AST_RESET_CLEARS: assert property (@(posedge proc_clk)
        proc_rst |=> (in_ready && !tx_started && !tx_done));  // R8
endmodule

bind iq_cdc_out iq_cdc_out_chk u_chk (
    .proc_clk(proc_clk), .proc_rst(proc_rst), .samp_clk(samp_clk), .samp_rst(samp_rst),
    .rd_en(rd_en), .rd_empty(rd_empty), .in_ready(in_ready), .tx_started(tx_started),
    .tx_done(tx_done), .rfa_i(rfa_i), .rfa_q(rfa_q), .rfb_i(rfb_i), .rfb_q(rfb_q)
);

// File: tb/iq_cdc_out_tb.sv
module iq_cdc_out_tb;
    localparam int CLK_PERIOD  = 10;
    localparam int SAMP_PERIOD = CLK_PERIOD * 4 + 2;
    localparam int ADDR_W      = 2;
    localparam int DEPTH       = 1 << ADDR_W;
    localparam int NSTREAM     = 40;

    logic pclk = 1'b0, sclk = 1'b0;
    logic pr = 1'b1, sr = 1'b1;
    logic tx_begin = 1'b0;
    logic [1:0] ant_mask = '0;
    logic in_valid = 1'b0, in_last = 1'b0;
    logic signed [15:0] in_i = '0, in_q = '0;
    logic in_ready, tx_started, tx_done;
    logic rd_en = 1'b0;
    logic signed [15:0] rfa_i, rfa_q, rfb_i, rfb_q;

    int n_tests = 0, n_fail = 0, done_cnt = 0;

    always #(CLK_PERIOD/2) pclk = ~pclk;
    always #(SAMP_PERIOD/2) sclk = ~sclk;

    iq_cdc_out #(.ADDR_W(ADDR_W), .SYNC_STAGES(2)) u_dut (
        .proc_clk(pclk), .proc_rst(pr), .tx_begin(tx_begin), .ant_mask(ant_mask),
        .in_valid(in_valid), .in_i(in_i), .in_q(in_q), .in_last(in_last),
        .in_ready(in_ready), .tx_started(tx_started), .tx_done(tx_done),
        .samp_clk(sclk), .samp_rst(sr), .rd_en(rd_en),
        .rfa_i(rfa_i), .rfa_q(rfa_q), .rfb_i(rfb_i), .rfb_q(rfb_q)
    );

    always @(posedge pclk) if (!pr && tx_done) done_cnt++;

    function automatic logic [63:0] pk(input logic [15:0] ai, aq, bi, bq);
        return {ai, aq, bi, bq};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic [63:0] exp);
        logic [63:0] act;
        act = pk(rfa_i, rfa_q, rfb_i, rfb_q);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic samp_step(input logic en);
        rd_en = en;
        @(negedge sclk);
    endtask

    task automatic settle();
        rd_en = 1'b0;
        repeat (6) @(negedge sclk);
    endtask

    task automatic begin_tx(input logic [1:0] m);
        @(negedge pclk);
        tx_begin = 1'b1; ant_mask = m;
        @(negedge pclk);
        tx_begin = 1'b0;
    endtask

    task automatic push(input logic [15:0] i, input logic [15:0] q, input logic last);
        @(negedge pclk);
        while (!in_ready) @(negedge pclk);
        in_valid = 1'b1; in_i = i; in_q = q; in_last = last;
        @(negedge pclk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic reset_all();
        pr = 1'b1; sr = 1'b1; rd_en = 1'b0; in_valid = 1'b0; tx_begin = 1'b0;
        repeat (4) @(negedge sclk);
        pr = 1'b0; sr = 1'b0;
        @(negedge sclk);
    endtask

    // R8: reset state
    task automatic t_reset();
        reset_all();
        expect_out("R8 outputs zero after reset", '0);
        chk(in_ready == 1'b1, "R8 in_ready after reset", 64'(in_ready), 64'd1);
        chk(tx_started == 1'b0 && tx_done == 1'b0, "R8 status low after reset",
            64'({tx_started, tx_done}), 64'd0);
        samp_step(1'b1);
        expect_out("R8 empty after reset reads zero", '0);
        samp_step(1'b0);
    endtask

    // R2 order, R3 hold, R4 empty zero, R6 started, R7 done
    task automatic t_basic();
        int base;
        reset_all();
        base = done_cnt;
        begin_tx(2'b11);
        for (int k = 1; k <= 4; k++) push(16'(k * 100), 16'(-k * 100), k == 4);
        settle();
        chk(tx_started == 1'b0, "R6 started low before output", 64'(tx_started), 64'd0);
        samp_step(1'b1);
        expect_out("R2 first sample", pk(16'd100, -16'sd100, 16'd100, -16'sd100));
        samp_step(1'b0);
        expect_out("R3 hold when rd_en low", pk(16'd100, -16'sd100, 16'd100, -16'sd100));
        samp_step(1'b0);
        chk(tx_started == 1'b1, "R6 started after first sample", 64'(tx_started), 64'd1);
        for (int k = 2; k <= 3; k++) begin
            samp_step(1'b1);
            expect_out("R2 sample order", pk(16'(k*100), 16'(-k*100), 16'(k*100), 16'(-k*100)));
        end
        samp_step(1'b0);
        samp_step(1'b0);
        chk(done_cnt == base, "R7 no done before last sample", 64'(done_cnt - base), 64'd0);
        samp_step(1'b1);
        expect_out("R2 last sample", pk(16'd400, -16'sd400, 16'd400, -16'sd400));
        repeat (3) samp_step(1'b0);
        chk(done_cnt == base + 1, "R7 one done pulse", 64'(done_cnt - base), 64'd1);
        chk(tx_started == 1'b0, "R6 started cleared after done", 64'(tx_started), 64'd0);
        samp_step(1'b1);
        expect_out("R4 empty read gives zero", '0);
        samp_step(1'b0);
    endtask

    // R5 masks carried per sample
    task automatic t_mask();
        int base;
        base = done_cnt;
        begin_tx(2'b01);
        push(16'd11, -16'sd11, 1'b0);
        push(16'd12, -16'sd12, 1'b1);
        begin_tx(2'b10);
        push(16'd21, -16'sd21, 1'b1);
        settle();
        samp_step(1'b1);
        expect_out("R5 mask 01 path A only", pk(16'd11, -16'sd11, 16'd0, 16'd0));
        samp_step(1'b1);
        expect_out("R5 mask 01 second sample", pk(16'd12, -16'sd12, 16'd0, 16'd0));
        samp_step(1'b1);
        expect_out("R5 mask 10 path B only", pk(16'd0, 16'd0, 16'd21, -16'sd21));
        repeat (3) samp_step(1'b0);
        chk(done_cnt == base + 2, "R7 done per packet", 64'(done_cnt - base), 64'd2);
    endtask

    // R1 full backpressure and dropped offer
    task automatic t_full();
        reset_all();
        begin_tx(2'b11);
        for (int k = 1; k <= DEPTH; k++) push(16'(k), 16'(k + 50), k == DEPTH);
        @(negedge pclk);
        chk(in_ready == 1'b0, "R1 in_ready low when full", 64'(in_ready), 64'd0);
        in_valid = 1'b1; in_i = 16'd999; in_q = 16'd999; in_last = 1'b0;
        repeat (3) @(negedge pclk);
        in_valid = 1'b0;
        settle();
        samp_step(1'b1);
        expect_out("R1 first stored sample", pk(16'd1, 16'd51, 16'd1, 16'd51));
        samp_step(1'b0);
        samp_step(1'b0);
        chk(in_ready == 1'b1, "R1 in_ready back after pop", 64'(in_ready), 64'd1);
        for (int k = 2; k <= DEPTH; k++) begin
            samp_step(1'b1);
            expect_out("R1 remaining samples", pk(16'(k), 16'(k + 50), 16'(k), 16'(k + 50)));
        end
        samp_step(1'b1);
        expect_out("R1 offer while full dropped", '0);
        samp_step(1'b0);
    endtask

    // R9 streaming at the guaranteed clock ratio
    task automatic t_stream();
        int base;
        reset_all();
        base = done_cnt;
        begin_tx(2'b11);
        fork
            begin
                int n = 0;
                while (n < NSTREAM) begin
                    @(negedge pclk);
                    in_valid = 1'b1;
                    in_i = 16'(n * 37 + 5);
                    in_q = 16'(-(n * 11) - 3);
                    in_last = (n == NSTREAM - 1);
                    if (in_ready) n++;
                end
                @(negedge pclk);
                in_valid = 1'b0; in_last = 1'b0;
            end
            begin
                repeat (6) @(negedge sclk);
                for (int k = 0; k < NSTREAM; k++) begin
                    samp_step(1'b1);
                    expect_out("R9 streamed sample",
                        pk(16'(k*37+5), 16'(-(k*11)-3), 16'(k*37+5), 16'(-(k*11)-3)));
                end
                samp_step(1'b0);
            end
        join
        repeat (3) samp_step(1'b0);
        chk(done_cnt == base + 1, "R7 done after stream", 64'(done_cnt - base), 64'd1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_mask();
        t_full();
        t_stream();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule